// File: doc/BRIEF.md
# ISA Host Bus Cycle Sequencer

This block is the host side of an ISA expansion bus. A local requester hands it one transfer at a time: an address, a direction, a memory or I/O space select, a byte or word width and the write data. The sequencer then plays out the whole bus cycle. It raises the address latch pulse and presents the address. It asserts the command strobe that matches the request, and counts wait states with a default ready timer. It ends the cycle early when the target asks for no wait states, and stretches the cycle while the target holds channel-ready low.

For a word request the sequencer asserts byte-high-enable and checks whether the target confirms 16-bit capability. For a memory target that confirmation may come with the address pulse or one clock later. For an I/O target it must come in the first command clock. If the target does not confirm, the word is carried as two byte cycles with one idle clock between them. The low byte goes to the even address. The high byte goes to the odd address and travels on the low data lanes. When the request has finished, a one-clock done pulse marks it and the read data is available.

One clock of `clk` is one bus clock. Every target input is sampled at the rising edge of `clk`.

Top module: `isa_host_seq`

## Requirements
- R1: After a synchronous reset, all command strobes and both low-memory strobes are high, `bale` is 0, `sbhe_n` is 1, `sd_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: An accepted request produces exactly one clock with `bale` high, which presents the address. The command clocks follow it directly. During them exactly one strobe is low, chosen by space and direction (I/O read `ior_n`, I/O write `iow_n`, memory read `memr_n`, memory write `memw_n`), and the address holds steady.
- R3: With `chrdy` high and `nows_n` high, a byte cycle has 1 + WAIT8 + 1 command clocks (6 by default). A confirmed word cycle has 1 + WAIT16 + 1 command clocks (3 by default).
- R4: While `chrdy` is sampled low in the first command clock or in a wait clock, another wait clock follows, and `nows_n` is ignored in that clock.
- R5: A low `nows_n` with `chrdy` high ends the cycle after the clock in which it is sampled, with one closing command clock. This holds in any wait clock of byte cycles and of confirmed word memory cycles. It also holds in the first command clock of a confirmed word memory cycle, which gives zero wait states. `nows_n` has no effect on confirmed word I/O cycles.
- R6: A word memory request is confirmed when `m16_n` is low at the end of the `bale` clock or at the end of the first command clock. A word I/O request is confirmed when `io16_n` is low at the end of the first command clock. `m16_n` is ignored for I/O cycles, and `io16_n` is ignored for memory cycles.
- R7: An unconfirmed word request runs as two byte cycles separated by one idle clock. The first cycle uses the even address with `sbhe_n` low. The second uses the odd address with `sbhe_n` high and carries the high byte on data lanes 7:0.
- R8: `smemr_n` and `smemw_n` follow `memr_n` and `memw_n` only when address bits 23:20 are all zero. Otherwise they stay high.
- R9: Read data is taken from `sd_in` at the end of the last command clock. A confirmed word takes all 16 bits. A byte read gives `{8'h00, sd_in[7:0]}`. A split read assembles the low byte from the first cycle and the high byte from `sd_in[7:0]` of the second.
- R10: For writes, `sd_oe` is high in every command clock and low elsewhere. `sd_out` carries the write word in the first cycle, and carries the high byte on lanes 7:0 in the second cycle of a split.
- R11: `done` is high for exactly one clock, the clock right after the last command clock. `req_ready` is high in that clock. At least one clock without a command strobe and without `bale` separates two bus cycles.
- R12: `aen` is low in every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 24 | Byte address of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wide | input | 1 | 1 = 16-bit word request, 0 = byte |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read data, valid while `done` is high |
| bale | output | 1 | Address latch pulse |
| aen | output | 1 | Address enable, low for host cycles |
| sbhe_n | output | 1 | Byte-high enable, active low |
| bus_addr | output | 24 | Address lines |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| smemr_n | output | 1 | Memory read strobe, low 1 MB only |
| smemw_n | output | 1 | Memory write strobe, low 1 MB only |
| sd_out | output | 16 | Data driven toward the bus |
| sd_oe | output | 1 | Data output enable |
| sd_in | input | 16 | Data received from the bus |
| chrdy | input | 1 | Channel ready from the target, low extends |
| nows_n | input | 1 | No-wait-state request from the target |
| m16_n | input | 1 | Memory target is 16-bit capable |
| io16_n | input | 1 | I/O target is 16-bit capable |

## Verification
The bound checker watches the following on every clock:
- the address pulse lasts one clock and the command clocks follow it directly;
- at most one command strobe is low;
- the address holds through the command clocks;
- `chrdy` low always gives another wait clock;
- the low-memory strobes stay inside their window;
- write enables appear only with a write strobe;
- `done` is a single-clock pulse;
- an idle clock follows each command phase;
- the second half of a split never asserts byte-high-enable.

The exact lengths of the cycles under different mixes of `chrdy`, `nows_n` and width confirmation can only be shown by the bench's scenarios, which compare each clock with a behavioural model. The same holds for the split into two byte cycles, the moment at which read data is taken, and how the read word is assembled.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

    localparam int unsigned BUS_AW = 24;
    localparam int unsigned BUS_DW = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_CMD,
        ST_WAIT,
        ST_END,
        ST_SPLIT
    } seq_state_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic              write;
        logic              mem;
        logic              wide;
        logic [BUS_DW-1:0] wdata;
    } xfer_req_t;

    typedef struct packed {
        logic ior;
        logic iow;
        logic memr;
        logic memw;
    } cmd_sel_t;

    // Address of one bus cycle: words go to the even byte first, the odd byte second.
    function automatic logic [BUS_AW-1:0] part_addr(input xfer_req_t r, input logic second);
        if (!r.wide) return r.addr;
        return {r.addr[BUS_AW-1:1], second};
    endfunction

    function automatic cmd_sel_t pick_cmd(input logic mem, input logic write);
        cmd_sel_t s;
        s.ior  = !mem && !write;
        s.iow  = !mem &&  write;
        s.memr =  mem && !write;
        s.memw =  mem &&  write;
        return s;
    endfunction

    function automatic logic in_cmd_phase(input seq_state_e s);
        return (s == ST_CMD) || (s == ST_WAIT) || (s == ST_END);
    endfunction

endpackage

// File: rtl/isa_wait_timer.sv
module isa_wait_timer #(
    parameter int unsigned WAIT8  = 4,
    parameter int unsigned WAIT16 = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_cmd,
    input  logic in_wait,
    input  logic fast16,
    input  logic is_mem,
    input  logic chrdy,
    input  logic nows_n,
    output logic finish
);
    localparam int unsigned MAXW = (WAIT8 > WAIT16) ? WAIT8 : WAIT16;
    localparam int unsigned CW   = (MAXW < 1) ? 1 : $clog2(MAXW + 1);
    localparam logic [CW-1:0] D8  = CW'(WAIT8);
    localparam logic [CW-1:0] D16 = CW'(WAIT16);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] left;
    logic          nows_en;
    logic          active;

    always_comb begin
        active  = in_cmd || in_wait;
        left    = in_cmd ? (fast16 ? D16 : D8) : cnt_q;
        // first command clock: only word memory may skip all waits;
        // wait clocks: everything except word I/O may be shortened
        nows_en = in_cmd ? (fast16 && is_mem) : !(fast16 && !is_mem);
        finish  = active && chrdy && ((left == '0) || (nows_en && !nows_n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (active && !finish) begin
            cnt_q <= (left == '0) ? '0 : left - 1'b1;
        end
    end

endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
    import isa_seq_pkg::*;
#(
    parameter int unsigned LOW_AW = 20
) (
    input  seq_state_e        st,
    input  xfer_req_t         req,
    input  logic              second,
    output logic              bale,
    output logic              sbhe_n,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic [BUS_DW-1:0] sd_out,
    output logic              sd_oe
);
    cmd_sel_t sel;
    logic     cmd_on;
    logic     cyc_on;
    logic     low_mb;

    always_comb begin
        cmd_on   = in_cmd_phase(st);
        cyc_on   = cmd_on || (st == ST_ALE);
        sel      = pick_cmd(req.mem, req.write);
        bus_addr = part_addr(req, second);
        low_mb   = (bus_addr >> LOW_AW) == '0;
        bale     = (st == ST_ALE);
        sbhe_n   = !(cyc_on && req.wide && !second);
        ior_n    = !(cmd_on && sel.ior);
        iow_n    = !(cmd_on && sel.iow);
        memr_n   = !(cmd_on && sel.memr);
        memw_n   = !(cmd_on && sel.memw);
        smemr_n  = !(cmd_on && sel.memr && low_mb);
        smemw_n  = !(cmd_on && sel.memw && low_mb);
        sd_oe    = cmd_on && req.write;
        sd_out   = second ? {req.wdata[BUS_DW-1:8], req.wdata[BUS_DW-1:8]} : req.wdata;
    end

endmodule

// File: rtl/isa_rd_capture.sv
module isa_rd_capture
    import isa_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              full_word,
    input  logic              second,
    input  logic [BUS_DW-1:0] sd_in,
    output logic [BUS_DW-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (capture) begin
            if (full_word)   rd_data <= sd_in;
            else if (second) rd_data[BUS_DW-1:8] <= sd_in[7:0];
            else             rd_data <= {8'h00, sd_in[7:0]};
        end
    end

endmodule

// File: rtl/isa_host_seq.sv
module isa_host_seq
    import isa_seq_pkg::*;
#(
    parameter int unsigned WAIT8  = 4,
    parameter int unsigned WAIT16 = 1,
    parameter int unsigned LOW_AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_wide,
    input  logic [BUS_DW-1:0] req_wdata,
    output logic              done,
    output logic [BUS_DW-1:0] rd_data,
    output logic              bale,
    output logic              aen,
    output logic              sbhe_n,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic [BUS_DW-1:0] sd_out,
    output logic              sd_oe,
    input  logic [BUS_DW-1:0] sd_in,
    input  logic              chrdy,
    input  logic              nows_n,
    input  logic              m16_n,
    input  logic              io16_n
);
    seq_state_e st_q;
    xfer_req_t  req_q;
    logic       second_q;
    logic       fast16_q;
    logic       m16_early_q;
    logic       done_q;
    logic       conf_now;
    logic       fast16_use;
    logic       finish;
    logic       last_part;

    always_comb begin
        conf_now   = req_q.wide && !second_q &&
                     (req_q.mem ? (m16_early_q || !m16_n) : !io16_n);
        fast16_use = (st_q == ST_CMD) ? conf_now : fast16_q;
        last_part  = !(req_q.wide && !fast16_q && !second_q);
    end

    isa_wait_timer #(.WAIT8(WAIT8), .WAIT16(WAIT16)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .in_cmd  (st_q == ST_CMD),
        .in_wait (st_q == ST_WAIT),
        .fast16  (fast16_use),
        .is_mem  (req_q.mem),
        .chrdy   (chrdy),
        .nows_n  (nows_n),
        .finish  (finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            req_q       <= '0;
            second_q    <= 1'b0;
            fast16_q    <= 1'b0;
            m16_early_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    req_q.addr  <= req_addr;
                    req_q.write <= req_write;
                    req_q.mem   <= req_mem;
                    req_q.wide  <= req_wide;
                    req_q.wdata <= req_wdata;
                    second_q    <= 1'b0;
                    fast16_q    <= 1'b0;
                    st_q        <= ST_ALE;
                end
                ST_ALE: begin
                    m16_early_q <= !m16_n;
                    st_q        <= ST_CMD;
                end
                ST_CMD: begin
                    fast16_q <= conf_now;
                    st_q     <= finish ? ST_END : ST_WAIT;
                end
                ST_WAIT: if (finish) st_q <= ST_END;
                ST_END: begin
                    done_q <= last_part;
                    st_q   <= last_part ? ST_IDLE : ST_SPLIT;
                end
                ST_SPLIT: begin
                    second_q <= 1'b1;
                    st_q     <= ST_ALE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    isa_strobe_gen #(.LOW_AW(LOW_AW)) u_strobe (
        .st       (st_q),
        .req      (req_q),
        .second   (second_q),
        .bale     (bale),
        .sbhe_n   (sbhe_n),
        .bus_addr (bus_addr),
        .ior_n    (ior_n),
        .iow_n    (iow_n),
        .memr_n   (memr_n),
        .memw_n   (memw_n),
        .smemr_n  (smemr_n),
        .smemw_n  (smemw_n),
        .sd_out   (sd_out),
        .sd_oe    (sd_oe)
    );

    isa_rd_capture u_rd (
        .clk       (clk),
        .rst       (rst),
        .capture   (st_q == ST_END),
        .full_word (fast16_q),
        .second    (second_q),
        .sd_in     (sd_in),
        .rd_data   (rd_data)
    );

    assign req_ready = (st_q == ST_IDLE);
    assign done      = done_q;
    assign aen       = 1'b0;

endmodule

// File: rtl/isa_host_seq_chk.sv
module isa_host_seq_chk
    import isa_seq_pkg::*;
#(
    parameter int unsigned LOW_AW = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              bale,
    input logic              sbhe_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              ior_n,
    input logic              iow_n,
    input logic              memr_n,
    input logic              memw_n,
    input logic              smemr_n,
    input logic              smemw_n,
    input logic              sd_oe,
    input logic              done,
    input logic              req_ready,
    input logic              chrdy,
    input seq_state_e        st,
    input logic              second
);
    logic cmd_any;
    logic above;
    assign cmd_any = !(ior_n && iow_n && memr_n && memw_n);
    assign above   = (bus_addr >> LOW_AW) != '0;

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
        bale |=> !bale);
    assert_ale_to_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        bale |=> cmd_any);
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({!ior_n, !iow_n, !memr_n, !memw_n}) <= 1);
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_any && $past(cmd_any)) |-> $stable(bus_addr));
    assert_chrdy_extend_R4: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_CMD || st == ST_WAIT) && !chrdy) |=> (st == ST_WAIT));
    assert_smem_window_R8: assert property (@(posedge clk) disable iff (rst)
        (!smemr_n || !smemw_n) |-> (!above && (!memr_n || !memw_n)));
    assert_smem_high_R8: assert property (@(posedge clk) disable iff (rst)
        above |-> (smemr_n && smemw_n));
    assert_split_byte_R7: assert property (@(posedge clk) disable iff (rst)
        second |-> sbhe_n);
    assert_oe_write_R10: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> (!iow_n || !memw_n));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_ready_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);
    assert_gap_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_any) |-> !bale);

endmodule

bind isa_host_seq isa_host_seq_chk #(.LOW_AW(LOW_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bale      (bale),
    .sbhe_n    (sbhe_n),
    .bus_addr  (bus_addr),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .memr_n    (memr_n),
    .memw_n    (memw_n),
    .smemr_n   (smemr_n),
    .smemw_n   (smemw_n),
    .sd_oe     (sd_oe),
    .done      (done),
    .req_ready (req_ready),
    .chrdy     (chrdy),
    .st        (st_q),
    .second    (second_q)
);

// File: tb/tb_isa_host_seq.sv
module tb_isa_host_seq;
    localparam int W8  = 4;
    localparam int W16 = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic        bale, aen, sbhe_n;
    logic [23:0] bus_addr;
    logic        ior_n, iow_n, memr_n, memw_n, smemr_n, smemw_n;
    logic [15:0] sd_out;
    logic        sd_oe;
    logic [15:0] sd_in = '0;
    logic        chrdy = 1'b1;
    logic        nows_n = 1'b1;
    logic        m16_n = 1'b1;
    logic        io16_n = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // target responder settings
    int m16_mode = 0;   // 0 never, 1 from the address pulse, 2 from the command
    int io16_mode = 0;
    int k_hold = 0;     // command clocks with chrdy low
    int nows_at = 0;    // command clock index with nows_n low (0 = never)
    int jc = 0;

    always #5 clk = ~clk;

    isa_host_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
        .req_wide(req_wide), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .bale(bale), .aen(aen), .sbhe_n(sbhe_n), .bus_addr(bus_addr),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .smemr_n(smemr_n), .smemw_n(smemw_n), .sd_out(sd_out), .sd_oe(sd_oe),
        .sd_in(sd_in), .chrdy(chrdy), .nows_n(nows_n), .m16_n(m16_n), .io16_n(io16_n)
    );

    wire cmd_any = !(ior_n && iow_n && memr_n && memw_n);

    always @(negedge clk) begin
        if (bale) jc = 0;
        if (cmd_any) jc = jc + 1;
        chrdy  <= !(cmd_any && jc <= k_hold);
        nows_n <= !(cmd_any && jc == nows_at);
        m16_n  <= !((m16_mode == 1 && (bale || cmd_any)) || (m16_mode == 2 && cmd_any));
        io16_n <= !((io16_mode == 1 && (bale || cmd_any)) || (io16_mode == 2 && cmd_any));
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // behavioural model of one bus cycle length (command clocks, closing clock included)
    function automatic int cmd_clocks(input bit fast, input bit mem, input int k, input int n);
        int d = fast ? W16 : W8;
        for (int j = 1; j < 500; j++) begin
            int  left = d - (j - 1);
            bit  ne;
            if (left < 0) left = 0;
            ne = (j == 1) ? (fast && mem) : !(fast && !mem);
            if ((j > k) && (left == 0 || (ne && j == n))) return j + 1;
        end
        return -1;
    endfunction

    task automatic xfer(input string rq, input logic [23:0] a, input bit wr, input bit mem,
                        input bit wide, input logic [15:0] wd, input logic [15:0] rp,
                        input int m16m, input int io16m, input int k, input int n,
                        input int exp_len0);
        bit fast = wide && (mem ? (m16m != 0) : (io16m != 0));
        int parts = (wide && !fast) ? 2 : 1;
        logic [3:0] exp_cmd = ~(mem ? (wr ? 4'b0001 : 4'b0010) : (wr ? 4'b0100 : 4'b1000));
        bit low = (a[23:20] == 4'h0);
        m16_mode = m16m; io16_mode = io16m; k_hold = k; nows_at = n;
        @(negedge clk);
        chk({rq, " R11 ready before request"}, req_ready, 1);
        req_addr = a; req_write = wr; req_mem = mem; req_wide = wide; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int p = 0; p < parts; p++) begin
            logic [23:0] ea = wide ? {a[23:1], p[0]} : a;
            bit          esb = !(wide && p == 0);
            int          len = cmd_clocks((p == 0) ? fast : 1'b0, mem, k, n);
            logic [15:0] good = (p == 1) ? {8'h00, rp[15:8]} : rp;
            if (p == 1) begin
                chk({rq, " R7 gap clock"}, {bale, cmd_any, done}, 3'b000);
                @(negedge clk);
            end
            if (p == 0 && exp_len0 > 0)
                chk({rq, " R3 model length"}, len, exp_len0);
            chk({rq, " R2 address pulse"}, {bale, cmd_any}, 2'b10);
            chk({rq, " R2 address"}, bus_addr, ea);
            chk({rq, " R7 byte-high enable"}, sbhe_n, esb);
            for (int c = 1; c <= len; c++) begin
                @(negedge clk);
                chk({rq, " R2 strobes"}, {bale, ior_n, iow_n, memr_n, memw_n}, {1'b0, exp_cmd});
                chk({rq, " R8 low-memory strobes"}, {smemr_n, smemw_n},
                    {!(mem && low && !wr), !(mem && low && wr)});
                chk({rq, " R12 aen"}, aen, 0);
                chk({rq, " R2 address hold"}, {sbhe_n, bus_addr}, {esb, ea});
                chk({rq, " R10 output enable"}, sd_oe, wr);
                if (wr && p == 0) chk({rq, " R10 write data"}, sd_out, wd);
                if (wr && p == 1) chk({rq, " R10 split high byte"}, sd_out[7:0], wd[15:8]);
                sd_in = (c == len) ? good : ~good;
            end
            @(negedge clk);
            sd_in = 16'h0000;
        end
        chk({rq, " R11 done pulse"}, {done, req_ready, cmd_any, bale, sd_oe}, 5'b11000);
        if (!wr) chk({rq, " R9 read data"}, rd_data, wide ? rp : {8'h00, rp[7:0]});
        @(negedge clk);
        chk({rq, " R11 done single"}, done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {ior_n, iow_n, memr_n, memw_n, smemr_n, smemw_n}, 6'h3f);
        chk("R1 reset control", {bale, sbhe_n, sd_oe, done, req_ready, aen}, 6'b010010);
        rst = 1'b0;
        // R3 byte I/O read, default waits
        xfer("T1", 24'h000300, 0, 0, 0, 16'h0, 16'h1234, 0, 0, 0, 0, 2 + W8);
        // R8 R10 byte memory write below 1 MB
        xfer("T2", 24'h0C8001, 1, 1, 0, 16'h00A5, 16'h0, 0, 0, 0, 0, 2 + W8);
        // R6 word memory read, early confirmation
        xfer("T3", 24'h0A0010, 0, 1, 1, 16'h0, 16'hBEEF, 1, 0, 0, 0, 2 + W16);
        // R6 word memory read, late confirmation
        xfer("T4", 24'h0A0020, 0, 1, 1, 16'h0, 16'hC0DE, 2, 0, 0, 0, 2 + W16);
        // R7 word memory write, never confirmed
        xfer("T5", 24'h0B0040, 1, 1, 1, 16'h5AC3, 16'h0, 0, 0, 0, 0, 2 + W8);
        // R5 R6 word I/O read with io16, nows_n ignored
        xfer("T6", 24'h000220, 0, 0, 1, 16'h0, 16'h7E81, 0, 2, 0, 2, 2 + W16);
        // R6 R7 word I/O read with only m16 asserted: split
        xfer("T7", 24'h000310, 0, 0, 1, 16'h0, 16'h9A3C, 1, 0, 0, 0, 2 + W8);
        // R5 byte I/O read shortened by nows_n in the second command clock
        xfer("T8", 24'h000378, 0, 0, 0, 16'h0, 16'h0066, 0, 0, 0, 2, 3);
        // R5 word memory read with zero wait states
        xfer("T9", 24'h0D0000, 0, 1, 1, 16'h0, 16'h4321, 1, 0, 0, 1, 2);
        // R4 channel-ready low for 7 clocks; nows_n inside that window ignored
        xfer("T10", 24'h0003F8, 0, 0, 0, 16'h0, 16'h00C4, 0, 0, 7, 3, 9);
        // R8 word memory read above 1 MB
        xfer("T11", 24'h2A0100, 0, 1, 1, 16'h0, 16'h8811, 1, 0, 0, 0, 2 + W16);
        // R4 R7 split memory read with chrdy extension on both halves
        xfer("T12", 24'h0E0200, 0, 1, 1, 16'h0, 16'h3CF0, 0, 1, 2, 0, 2 + W8);
        // R5 word memory write, nows_n in the first wait clock
        xfer("T13", 24'h180000, 1, 1, 1, 16'hD00D, 16'h0, 2, 0, 0, 2, 3);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule